// File: doc/BRIEF.md
# Transfer Sniffer Accumulator

This unit watches the element stream of a data-transfer engine and folds every qualified element into a 32-bit accumulator. The fold is either a plain sum or a reflected CRC32 step, chosen by a function field in a control register. Only elements that meet two conditions are folded: the element's own sniff-enable flag must be set, and it must come from the engine picked by a static selection input.

Both the accumulator and the control register can be written through four aliases: a plain load, a bit-set (OR), a bit-clear (AND-NOT) and a bit-toggle (XOR). With these aliases and the adder, the accumulator can act as a small ALU register for transfer-driven computation. The accumulator view can be bit-reversed, inverted, or both, as selected by two control flags. This allows shifts and negation to be built from sequences of transfers.

Both views are registered. Each shows the state that follows the most recent clock edge.

Top module: `sniff_accum`

## Requirements
- R1: After synchronous reset the accumulator and control register are zero, so `acc_view` and `ctrl_view` read 0.
- R2: A write with `reg_sel`=0 and `reg_op`=0 loads `reg_wdata` into the accumulator.
- R3: With `reg_sel`=0 and `reg_op`=1, the written value is ORed into the accumulator.
- R4: With `reg_sel`=0 and `reg_op`=2, every accumulator bit that is set in the written value is cleared.
- R5: With `reg_sel`=0 and `reg_op`=3, the written value is XORed into the accumulator. An all-ones value inverts it.
- R6: When control bits 8:5 are all ones, each qualified element is added to the accumulator modulo 2^32.
- R7: When control bits 8:5 are all zeros, each qualified element advances a reflected CRC32 (polynomial 0xEDB88320, no pre- or post-inversion) over all 32 element bits, least significant bit first, in one cycle.
- R8: Any other value of control bits 8:5 leaves the accumulator unchanged on qualified elements.
- R9: An element is ignored unless `el_valid` and `el_sniff` are both high and `el_chan` equals `watch_chan`.
- R10: Control bit 10 makes `acc_view` show the accumulator bit-reversed (bit i appears at 31-i). Control bit 11 makes it show the accumulator inverted. With both bits set, the view is the inverse of the reversed value.
- R11: With `reg_sel`=1, the four `reg_op` codes load, set, clear or toggle bits 11:0 of the control register, which `ctrl_view` shows.
- R12: When an accumulator register write and a qualified element arrive in the same cycle, the write takes effect and the element is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| watch_chan | input | 4 | Static selection of the observed engine |
| el_valid | input | 1 | An element transfer occurs this cycle |
| el_chan | input | 4 | Engine issuing the element |
| el_sniff | input | 1 | Element's sniff-enable qualifier |
| el_data | input | 32 | Element data |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = accumulator, 1 = control |
| reg_op | input | 2 | 0 load, 1 set, 2 clear, 3 toggle |
| reg_wdata | input | 32 | Register write data |
| acc_view | output | 32 | Accumulator after optional reverse/invert |
| ctrl_view | output | 12 | Control register contents |

## Verification
Every result, whether a register write, a fold or a change of view flags, is due on the outputs in the cycle after the edge that samples the stimulus. No extra latency applies, because both views are registered from next-state values. The bench drives inputs just after a rising edge and samples just after the following one, so each check sees exactly one update. It sweeps many generated values through every alias and both fold functions against an arithmetic model, and confirms that unqualified or same-cycle-overridden elements leave the view untouched.

// File: rtl/sniff_pkg.sv
package sniff_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_XOR  = 2'd3
  } alias_op_e;
endpackage

// File: rtl/sniff_alias.sv
module sniff_alias
  import sniff_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  alias_op_e    op,
  input  logic [W-1:0] val,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_LOAD: res = val;
      OP_SET:  res = cur | val;
      OP_CLR:  res = cur & ~val;
      OP_XOR:  res = cur ^ val;
      default: res = cur;
    endcase
  end
endmodule

// File: rtl/sniff_fold.sv
module sniff_fold #(
  parameter int          W    = 32,
  parameter int          FN_W = 4,
  parameter logic [W-1:0] POLY = 32'hEDB8_8320
) (
  input  logic [W-1:0]    acc,
  input  logic [W-1:0]    elem,
  input  logic [FN_W-1:0] fn,
  output logic [W-1:0]    res
);
  localparam logic [FN_W-1:0] FN_ADD = {FN_W{1'b1}};
  localparam logic [FN_W-1:0] FN_CRC = {FN_W{1'b0}};

  logic [W-1:0] crc_next;
  logic         fb;

  // reflected CRC, one element bit per unrolled step, LSB first
  always_comb begin
    crc_next = acc;
    fb       = 1'b0;
    for (int i = 0; i < W; i++) begin
      fb       = crc_next[0] ^ elem[i];
      crc_next = (crc_next >> 1) ^ (fb ? POLY : '0);
    end
  end

  always_comb begin
    if (fn == FN_ADD)      res = acc + elem;
    else if (fn == FN_CRC) res = crc_next;
    else                   res = acc;
  end
endmodule

// File: rtl/sniff_view.sv
module sniff_view #(
  parameter int W       = 32,
  parameter int CTRL_W  = 12,
  parameter int REV_BIT = 10,
  parameter int INV_BIT = 11
) (
  input  logic [W-1:0]      acc,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [W-1:0]      view
);
  logic [W-1:0] flipped;
  logic [W-1:0] ordered;

  for (genvar g = 0; g < W; g++) begin : g_rev
    assign flipped[g] = acc[W-1-g];
  end

  assign ordered = ctrl[REV_BIT] ? flipped : acc;
  assign view    = ctrl[INV_BIT] ? ~ordered : ordered;
endmodule

// File: rtl/sniff_accum.sv
module sniff_accum
  import sniff_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          CTRL_W  = 12,
  parameter int          CHAN_W  = 4,
  parameter int          FN_LO   = 5,
  parameter int          FN_W    = 4,
  parameter int          REV_BIT = 10,
  parameter int          INV_BIT = 11,
  parameter logic [31:0] POLY    = 32'hEDB8_8320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAN_W-1:0] watch_chan,
  input  logic              el_valid,
  input  logic [CHAN_W-1:0] el_chan,
  input  logic              el_sniff,
  input  logic [DATA_W-1:0] el_data,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [1:0]        reg_op,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] acc_view,
  output logic [CTRL_W-1:0] ctrl_view
);
  localparam int FN_HI = FN_LO + FN_W - 1;

  logic [DATA_W-1:0] acc_q, acc_d, acc_alias, acc_fold, view_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d, ctrl_alias;
  logic              el_hit, data_wr, ctrl_wr;
  alias_op_e         op;

  assign op      = alias_op_e'(reg_op);
  assign el_hit  = el_valid && el_sniff && (el_chan == watch_chan);
  assign data_wr = reg_wr && !reg_sel;
  assign ctrl_wr = reg_wr && reg_sel;

  sniff_alias #(.W(DATA_W)) u_data_alias (
    .cur(acc_q), .op(op), .val(reg_wdata), .res(acc_alias)
  );

  sniff_alias #(.W(CTRL_W)) u_ctrl_alias (
    .cur(ctrl_q), .op(op), .val(reg_wdata[CTRL_W-1:0]), .res(ctrl_alias)
  );

  sniff_fold #(.W(DATA_W), .FN_W(FN_W), .POLY(POLY[DATA_W-1:0])) u_fold (
    .acc(acc_q), .elem(el_data), .fn(ctrl_q[FN_HI:FN_LO]), .res(acc_fold)
  );

  // register writes win over a same-cycle sniffed element
  always_comb begin
    if (data_wr)     acc_d = acc_alias;
    else if (el_hit) acc_d = acc_fold;
    else             acc_d = acc_q;
    ctrl_d = ctrl_wr ? ctrl_alias : ctrl_q;
  end

  sniff_view #(.W(DATA_W), .CTRL_W(CTRL_W), .REV_BIT(REV_BIT), .INV_BIT(INV_BIT)) u_view (
    .acc(acc_d), .ctrl(ctrl_d), .view(view_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      ctrl_q    <= '0;
      acc_view  <= '0;
      ctrl_view <= '0;
    end else begin
      acc_q     <= acc_d;
      ctrl_q    <= ctrl_d;
      acc_view  <= view_d;
      ctrl_view <= ctrl_d;
    end
  end
endmodule

// File: rtl/sniff_accum_chk.sv
module sniff_accum_chk #(
  parameter int DATA_W  = 32,
  parameter int CTRL_W  = 12,
  parameter int CHAN_W  = 4,
  parameter int REV_BIT = 10,
  parameter int INV_BIT = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [CHAN_W-1:0] watch_chan,
  input logic              el_valid,
  input logic [CHAN_W-1:0] el_chan,
  input logic              el_sniff,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [1:0]        reg_op,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] acc_view,
  input logic [CTRL_W-1:0] ctrl_view
);
  logic hit;
  assign hit = el_valid && el_sniff && (el_chan == watch_chan);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (acc_view == '0 && ctrl_view == '0));

  assert_plain_load_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel && reg_op == 2'd0 && !ctrl_view[REV_BIT] && !ctrl_view[INV_BIT])
    |=> acc_view == $past(reg_wdata));

  assert_xor_invert_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel && reg_op == 2'd3 && reg_wdata == '1)
    |=> acc_view == ~$past(acc_view));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && !hit) |=> ($stable(acc_view) && $stable(ctrl_view)));

  assert_ctrl_set_R11: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel && reg_op == 2'd1)
    |=> (ctrl_view & $past(reg_wdata[CTRL_W-1:0])) == $past(reg_wdata[CTRL_W-1:0]));

  assert_ctrl_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel && reg_op == 2'd2)
    |=> (ctrl_view & $past(reg_wdata[CTRL_W-1:0])) == '0);
endmodule

bind sniff_accum sniff_accum_chk #(
  .DATA_W(DATA_W), .CTRL_W(CTRL_W), .CHAN_W(CHAN_W),
  .REV_BIT(REV_BIT), .INV_BIT(INV_BIT)
) u_chk (
  .clk(clk), .rst(rst), .watch_chan(watch_chan), .el_valid(el_valid),
  .el_chan(el_chan), .el_sniff(el_sniff), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_op(reg_op), .reg_wdata(reg_wdata), .acc_view(acc_view), .ctrl_view(ctrl_view)
);

// File: tb/tb_sniff_accum.sv
module tb_sniff_accum;
  localparam int CLK_P = 10;
  localparam logic [3:0] WATCH = 4'd6;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  watch_chan;
  logic        el_valid, el_sniff;
  logic [3:0]  el_chan;
  logic [31:0] el_data;
  logic        reg_wr, reg_sel;
  logic [1:0]  reg_op;
  logic [31:0] reg_wdata;
  logic [31:0] acc_view;
  logic [11:0] ctrl_view;

  int tests = 0;
  int fails = 0;
  logic [31:0] acc_m;
  logic [11:0] ctrl_m;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  sniff_accum dut (
    .clk(clk), .rst(rst), .watch_chan(watch_chan), .el_valid(el_valid),
    .el_chan(el_chan), .el_sniff(el_sniff), .el_data(el_data),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_op(reg_op), .reg_wdata(reg_wdata),
    .acc_view(acc_view), .ctrl_view(ctrl_view)
  );

  function automatic logic [31:0] nxt(input logic [31:0] v);
    logic [31:0] t = v;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [31:0] alias_m(input logic [31:0] c, input logic [1:0] op, input logic [31:0] v);
    case (op)
      2'd0: return v;
      2'd1: return c | v;
      2'd2: return c & ~v;
      default: return c ^ v;
    endcase
  endfunction

  // reference CRC: table-free, one byte at a time, low byte first
  function automatic logic [31:0] crc_m(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 4; b++) begin
      r = r ^ {24'd0, d[8*b +: 8]};
      for (int k = 0; k < 8; k++)
        r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [31:0] view_m(input logic [31:0] a, input logic [11:0] c);
    logic [31:0] r = a;
    if (c[10]) for (int i = 0; i < 32; i++) r[i] = a[31-i];
    if (c[11]) r = ~r;
    return r;
  endfunction

  task automatic check(input string req);
    logic [31:0] ev = view_m(acc_m, ctrl_m);
    tests++;
    if (acc_view !== ev || ctrl_view !== ctrl_m) begin
      fails++;
      $display("FAIL %s acc_view=%h exp=%h ctrl_view=%h exp=%h", req, acc_view, ev, ctrl_view, ctrl_m);
    end
  endtask

  task automatic idle();
    reg_wr = 0; el_valid = 0; el_sniff = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic wr(input logic sel, input logic [1:0] op, input logic [31:0] v, input string req);
    reg_wr = 1; reg_sel = sel; reg_op = op; reg_wdata = v;
    if (sel) ctrl_m = alias_m({20'd0, ctrl_m}, op, v)[11:0];
    else     acc_m  = alias_m(acc_m, op, v);
    tick();
    check(req);
  endtask

  function automatic logic [31:0] fold_m(input logic [31:0] a, input logic [31:0] d);
    if (ctrl_m[8:5] == 4'hF) return a + d;
    if (ctrl_m[8:5] == 4'h0) return crc_m(a, d);
    return a;
  endfunction

  task automatic sniff(input logic v, input logic en, input logic [3:0] ch, input logic [31:0] d, input string req);
    el_valid = v; el_sniff = en; el_chan = ch; el_data = d;
    if (v && en && ch == WATCH) acc_m = fold_m(acc_m, d);
    tick();
    check(req);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    watch_chan = WATCH;
    el_chan = 0; el_data = 0; reg_sel = 0; reg_op = 0; reg_wdata = 0;
    idle();
    rst = 1;
    @(posedge clk); @(posedge clk); #1;
    rst = 0;
    acc_m = 0; ctrl_m = 0;
    check("R1");

    // R2 load sweep
    for (int i = 0; i < 16; i++) begin
      seed = nxt(seed);
      wr(0, 2'd0, seed, "R2");
    end
    // R3 R4 R5 alias sweeps
    for (int i = 0; i < 16; i++) begin
      seed = nxt(seed); wr(0, 2'd1, seed, "R3");
      seed = nxt(seed); wr(0, 2'd2, seed, "R4");
      seed = nxt(seed); wr(0, 2'd3, seed, "R5");
    end
    wr(0, 2'd3, 32'hFFFF_FFFF, "R5");

    // R6 add mode, incl. wrap
    wr(1, 2'd0, 12'h1E0, "R11");
    wr(0, 2'd0, 32'hFFFF_FFF0, "R2");
    sniff(1, 1, WATCH, 32'h0000_0020, "R6");
    for (int i = 0; i < 24; i++) begin
      seed = nxt(seed); sniff(1, 1, WATCH, seed, "R6");
    end

    // R9 unqualified elements
    sniff(1, 0, WATCH, 32'h1111_1111, "R9");
    sniff(1, 1, WATCH + 4'd1, 32'h2222_2222, "R9");
    sniff(0, 1, WATCH, 32'h3333_3333, "R9");

    // R7 CRC mode via clear alias on function field
    wr(1, 2'd2, 12'h1E0, "R11");
    wr(0, 2'd0, 32'hFFFF_FFFF, "R2");
    for (int i = 0; i < 24; i++) begin
      seed = nxt(seed); sniff(1, 1, WATCH, seed, "R7");
    end

    // R8 other function codes
    for (int f = 1; f < 15; f++) begin
      wr(1, 2'd0, 12'(f << 5), "R11");
      seed = nxt(seed); sniff(1, 1, WATCH, seed, "R8");
    end

    // R10 view flags, R11 ctrl aliases
    wr(1, 2'd0, 12'h1E0, "R11");
    wr(0, 2'd0, 32'h0000_0001, "R2");
    wr(1, 2'd1, 12'h400, "R10");
    wr(1, 2'd1, 12'h800, "R10");
    wr(1, 2'd2, 12'h400, "R10");
    wr(1, 2'd3, 12'h C00, "R10");
    wr(1, 2'd3, 12'h400, "R11");
    for (int i = 0; i < 8; i++) begin
      seed = nxt(seed); wr(0, 2'd0, seed, "R10");
      sniff(1, 1, WATCH, 32'd3, "R10");
    end
    wr(1, 2'd0, 12'h1E0, "R11");

    // R12 write wins over same-cycle element
    for (int i = 0; i < 8; i++) begin
      seed = nxt(seed);
      el_valid = 1; el_sniff = 1; el_chan = WATCH; el_data = 32'h0101_0101;
      reg_wr = 1; reg_sel = 0; reg_op = 2'(i); reg_wdata = seed;
      acc_m = alias_m(acc_m, 2'(i), seed);
      tick();
      check("R12");
    end

    // R1 again
    rst = 1; tick(); rst = 0;
    acc_m = 0; ctrl_m = 0;
    check("R1");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule